// File: doc/BRIEF.md
# Bank Activate Window Limiter

This block sits beside a DDR2 command scheduler and judges, every cycle, whether one proposed command may go out on the command bus now. The scheduler presents a candidate (operation code and bank) and the block answers with `allow` in the same cycle, combinationally from its timing state. When the scheduler raises `issue`, the command counts as sent: the block updates its timers even if `allow` was low, and in that case it raises `violation` for one cycle.

The block tracks, for each bank, whether a row is open and how long ago it was last activated and last precharged. Shared across banks, it tracks the spacing between any two activates, the spacing between column commands, and a history of the four most recent activates so that no fifth activate lands inside the rolling four-activate window. Single-bank precharge and precharge-all carry different recovery times. All limits are given in picoseconds and turned into whole clock counts at elaboration, rounding up against the clock period parameter. Address mapping, data movement and refresh are handled elsewhere.

Top module: `act_window_limiter`

## Requirements
- R1: An activate (code 1) is allowed only when its bank has no open row, at least RC cycles have passed since that bank's last activate, and that bank's precharge recovery (R7) has elapsed.
- R2: Any two activates, to any banks, are at least RRD cycles apart.
- R3: An activate is allowed only when the fourth most recent activate was issued at least FAW cycles earlier.
- R4: A read (code 2) or write (code 3) is allowed only to a bank with an open row whose activate is at least RCD cycles old.
- R5: Two column commands (read or write, any banks) are at least CCD cycles apart.
- R6: A single-bank precharge (code 4) to an open bank needs that bank's activate to be at least RAS cycles old; to a closed bank it is always allowed. A precharge-all (code 5) needs this for every open bank. Either closes the rows it addresses.
- R7: After a single-bank precharge the bank may be activated again after RP cycles; after a precharge-all every bank waits RPA cycles, RPA being RP plus one.
- R8: `violation` is high for exactly the cycle after an edge at which `issue` was sampled with `allow` low; the command is still applied to the timing state.
- R9: `ras_overrun` is high while any bank's row has been open for more than RAS_MAX cycles.
- R10: After reset all banks are closed, all windows count as satisfied, and `violation` and `ras_overrun` are low.
- R11: Codes 0, 6 and 7 are no-operations: always allowed, never flagged, and they change no timer.
- R12: Each cycle count is the picosecond limit divided by the clock period, rounded up; CCD is given directly in cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_cmd | input | 3 | Candidate operation: 0 none, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all |
| cand_bank | input | $clog2(NUM_BANKS) | Bank of the candidate |
| issue | input | 1 | The candidate is sent on this edge |
| allow | output | 1 | The candidate meets every timing limit this cycle |
| violation | output | 1 | One-cycle flag for a command sent while not allowed |
| ras_overrun | output | 1 | Some open row exceeds the maximum row-active time |

## Verification
The bench probes each limit one cycle before and exactly at the cycle it expires, so an off-by-one counter (one that starts at zero instead of one, or compares with greater-than) flips an answer at one of the two probes. The fifth activate is placed where spacing between neighbours is met but the window is not, which a design that only checks adjacent activates lets through. The same-bank row cycle is made longer than active time plus precharge so it alone decides, and precharge-all recovery is probed at the cycle where single-bank recovery would already pass. A command sent while blocked is followed by probes that only pass if it was recorded, catching a design that drops it.

// File: rtl/awl_pkg.sv
// Shared definitions for the activate window limiter.
// Assumes limits are supplied in picoseconds and the clock period is nonzero.
package awl_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ACT   = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_PRE   = 3'd4,
        OP_PREA  = 3'd5
    } op_e;

    // Whole clock count covering a picosecond limit, rounded up.
    function automatic int ps_to_ck(input int lim_ps, input int clk_ps);
        return (lim_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/awl_since.sv
// Saturating "cycles since event" counter.
// After an event at an edge, the next cycle reads 1 and it climbs to LIMIT.
// Assumes LIMIT >= 1. Reset starts it saturated (the window counts as met).
module awl_since #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic reached
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] SAT = W'(LIMIT);

    logic [W-1:0] age_q;

    // Restart on the event, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= SAT;
        else if (evt)          age_q <= W'(1);
        else if (age_q < SAT)  age_q <= age_q + W'(1);
    end

    assign reached = (age_q >= SAT);

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && LIMIT > 1) |=> !reached);

endmodule

// File: rtl/awl_faw_history.sv
// Keeps the ages of the last ACTS activates, youngest first.
// window_ok is high when the oldest kept activate is FAW_CK or more cycles old.
// Assumes FAW_CK >= 1; reset fills the history with aged-out entries.
module awl_faw_history #(
    parameter int FAW_CK = 15,
    parameter int ACTS   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_fire,
    output logic window_ok
);
    localparam int W = $clog2(FAW_CK + 1);
    localparam logic [W-1:0] SAT = W'(FAW_CK);

    logic [W-1:0] age_q [ACTS];

    // Saturating increment of one age entry.
    function automatic logic [W-1:0] bump(input logic [W-1:0] a);
        return (a < SAT) ? a + W'(1) : a;
    endfunction

    // Entry 0 ages or takes the new activate.
    always_ff @(posedge clk) begin
        if (!rst_n)        age_q[0] <= SAT;
        else if (act_fire) age_q[0] <= W'(1);
        else               age_q[0] <= bump(age_q[0]);
    end

    for (genvar i = 1; i < ACTS; i++) begin : g_hist
        // Each older entry ages, or takes its younger neighbour on a shift.
        always_ff @(posedge clk) begin
            if (!rst_n)        age_q[i] <= SAT;
            else if (act_fire) age_q[i] <= bump(age_q[i-1]);
            else               age_q[i] <= bump(age_q[i]);
        end

        p_faw_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            age_q[i-1] <= age_q[i]);
    end

    assign window_ok = (age_q[ACTS-1] >= SAT);

endmodule

// File: rtl/awl_bank_timer.sv
// Timing state of one bank: open flag, age of the last activate,
// age of the last precharge and which recovery that precharge demands.
// Assumes the caller only raises one hit per cycle.
module awl_bank_timer #(
    parameter int RC_CK     = 22,
    parameter int RCD_CK    = 6,
    parameter int RAS_CK    = 16,
    parameter int RASMAX_CK = 28000,
    parameter int RP_CK     = 6,
    parameter int RPA_CK    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_hit,
    input  logic pre_hit,
    input  logic prea_hit,
    output logic is_open,
    output logic act_ok,
    output logic col_ok,
    output logic pre_ok,
    output logic overrun
);
    localparam int AW = $clog2(RASMAX_CK + 2);
    localparam logic [AW-1:0] ACT_SAT = AW'(RASMAX_CK + 1);
    localparam int PW = $clog2(RPA_CK + 1);
    localparam logic [PW-1:0] PRE_SAT = PW'(RPA_CK);

    logic [AW-1:0] act_age_q;
    logic [PW-1:0] pre_age_q;
    logic [PW-1:0] pre_need_q;
    logic          open_q;

    // Row open flag: set by activate, cleared by either precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   open_q <= 1'b0;
        else if (act_hit)             open_q <= 1'b1;
        else if (pre_hit || prea_hit) open_q <= 1'b0;
    end

    // Age of the latest activate, saturating past the maximum active time.
    always_ff @(posedge clk) begin
        if (!rst_n)                    act_age_q <= ACT_SAT;
        else if (act_hit)              act_age_q <= AW'(1);
        else if (act_age_q < ACT_SAT)  act_age_q <= act_age_q + AW'(1);
    end

    // Age of the latest precharge and the recovery it requires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_age_q  <= PRE_SAT;
            pre_need_q <= PW'(RP_CK);
        end else if (pre_hit || prea_hit) begin
            pre_age_q  <= PW'(1);
            pre_need_q <= prea_hit ? PW'(RPA_CK) : PW'(RP_CK);
        end else if (pre_age_q < PRE_SAT) begin
            pre_age_q  <= pre_age_q + PW'(1);
        end
    end

    assign is_open = open_q;
    assign act_ok  = !open_q && (act_age_q >= AW'(RC_CK)) && (pre_age_q >= pre_need_q);
    assign col_ok  = open_q && (act_age_q >= AW'(RCD_CK));
    assign pre_ok  = !open_q || (act_age_q >= AW'(RAS_CK));
    assign overrun = open_q && (act_age_q > AW'(RASMAX_CK));

    p_open_after_act_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |=> is_open);

    p_closed_after_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit || prea_hit) && !act_hit |=> !is_open);

    p_recovery_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit || prea_hit) && RP_CK > 1 |=> !act_ok);

endmodule

// File: rtl/act_window_limiter.sv
// Admission check for DDR2 commands against inter-command timing limits.
// Answers allow combinationally for the presented candidate; a command
// sent with issue is always applied to the timing state, and one sent while
// not allowed is flagged on violation in the following cycle.
// Assumes NUM_BANKS is 4 or 8 and limits are given in picoseconds.
module act_window_limiter #(
    parameter int NUM_BANKS  = 8,
    parameter int CLK_PS     = 2500,
    parameter int FAW_PS     = 37500,
    parameter int RRD_PS     = 7500,
    parameter int RC_PS      = 55000,
    parameter int RCD_PS     = 15000,
    parameter int RAS_PS     = 40000,
    parameter int RASMAX_PS  = 70000000,
    parameter int RP_PS      = 15000,
    parameter int CCD_CK     = 2,
    parameter int FAW_ACTS   = 4,
    localparam int BW        = $clog2(NUM_BANKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cand_cmd,
    input  logic [BW-1:0] cand_bank,
    input  logic          issue,
    output logic          allow,
    output logic          violation,
    output logic          ras_overrun
);
    import awl_pkg::*;

    localparam int FAW_CK    = ps_to_ck(FAW_PS, CLK_PS);
    localparam int RRD_CK    = ps_to_ck(RRD_PS, CLK_PS);
    localparam int RC_CK     = ps_to_ck(RC_PS, CLK_PS);
    localparam int RCD_CK    = ps_to_ck(RCD_PS, CLK_PS);
    localparam int RAS_CK    = ps_to_ck(RAS_PS, CLK_PS);
    localparam int RASMAX_CK = ps_to_ck(RASMAX_PS, CLK_PS);
    localparam int RP_CK     = ps_to_ck(RP_PS, CLK_PS);
    localparam int RPA_CK    = RP_CK + 1;

    op_e op;
    logic is_act, is_col, is_pre, is_prea;
    logic rrd_ok, ccd_ok, faw_ok;
    logic [NUM_BANKS-1:0] open_v, act_ok_v, col_ok_v, pre_ok_v, over_v;
    logic violation_q;

    assign op      = op_e'(cand_cmd);
    assign is_act  = (op == OP_ACT);
    assign is_col  = (op == OP_READ) || (op == OP_WRITE);
    assign is_pre  = (op == OP_PRE);
    assign is_prea = (op == OP_PREA);

    awl_since #(.LIMIT(RRD_CK)) u_rrd (
        .clk(clk), .rst_n(rst_n), .evt(issue && is_act), .reached(rrd_ok));

    awl_since #(.LIMIT(CCD_CK)) u_ccd (
        .clk(clk), .rst_n(rst_n), .evt(issue && is_col), .reached(ccd_ok));

    awl_faw_history #(.FAW_CK(FAW_CK), .ACTS(FAW_ACTS)) u_faw (
        .clk(clk), .rst_n(rst_n), .act_fire(issue && is_act), .window_ok(faw_ok));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = issue && (cand_bank == BW'(b));

        awl_bank_timer #(
            .RC_CK(RC_CK), .RCD_CK(RCD_CK), .RAS_CK(RAS_CK),
            .RASMAX_CK(RASMAX_CK), .RP_CK(RP_CK), .RPA_CK(RPA_CK)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_hit  (sel && is_act),
            .pre_hit  (sel && is_pre),
            .prea_hit (issue && is_prea),
            .is_open  (open_v[b]),
            .act_ok   (act_ok_v[b]),
            .col_ok   (col_ok_v[b]),
            .pre_ok   (pre_ok_v[b]),
            .overrun  (over_v[b])
        );
    end

    // Combine per-bank and shared limits for the candidate.
    always_comb begin
        unique case (op)
            OP_ACT:            allow = act_ok_v[cand_bank] && rrd_ok && faw_ok;
            OP_READ, OP_WRITE: allow = col_ok_v[cand_bank] && ccd_ok;
            OP_PRE:            allow = pre_ok_v[cand_bank];
            OP_PREA:           allow = &pre_ok_v;
            default:           allow = 1'b1;
        endcase
    end

    // One-cycle flag for a command sent against the limits.
    always_ff @(posedge clk) begin
        if (!rst_n) violation_q <= 1'b0;
        else        violation_q <= issue && !allow;
    end

    assign violation   = violation_q;
    assign ras_overrun = |over_v;

    p_viol_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !allow) |=> violation);

    p_viol_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && !allow) |=> !violation);

    p_open_blocks_act_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && open_v[cand_bank]) |-> !allow);

    p_overrun_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ras_overrun |-> (open_v != '0));

    if (CCD_CK > 1) begin : g_ccd_chk
        p_col_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && is_col) |=> !(is_col && allow));
    end

endmodule

// File: tb/act_window_limiter_bench.sv
// Directed bench: one task per scenario, probing each limit just before and at expiry.
module act_window_limiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BW = 3;
    // Expected cycle counts at 2500 ps with a 65 ns row cycle (R12).
    localparam int E_RRD = 3, E_FAW = 15, E_RC = 26, E_RCD = 6;
    localparam int E_RAS = 16, E_RP = 6, E_RPA = 7, E_CCD = 2, E_RASMAX = 28000;

    localparam logic [2:0] C_NONE = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3;
    localparam logic [2:0] C_PRE = 3'd4, C_PREA = 3'd5, C_SPARE = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cand_cmd = '0;
    logic [BW-1:0] cand_bank = '0;
    logic issue = 1'b0;
    logic allow, violation, ras_overrun;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    act_window_limiter #(.NUM_BANKS(8), .CLK_PS(2500), .RC_PS(65000)) u_act_window_limiter (
        .clk(clk), .rst_n(rst_n), .cand_cmd(cand_cmd), .cand_bank(cand_bank),
        .issue(issue), .allow(allow), .violation(violation), .ras_overrun(ras_overrun));

    task automatic chk(input logic got, input logic exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic probe(input logic [2:0] c, input int b, input logic exp, input string what);
        cand_cmd = c;
        cand_bank = BW'(b);
        issue = 1'b0;
        #1;
        chk(allow, exp, what);
    endtask

    // Send a command on the next edge; returns at the following negedge.
    task automatic fire(input logic [2:0] c, input int b);
        cand_cmd = c;
        cand_bank = BW'(b);
        issue = 1'b1;
        @(posedge clk);
        @(negedge clk);
        issue = 1'b0;
        cand_cmd = C_NONE;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        issue = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        probe(C_ACT, 0, 1'b1, "R10 activate allowed after reset");
        probe(C_RD, 0, 1'b0, "R10 read to closed bank after reset");
        chk(violation, 1'b0, "R10 violation low after reset");
        chk(ras_overrun, 1'b0, "R10 overrun low after reset");
    endtask

    task automatic t_noop();
        do_reset();
        fire(C_NONE, 0);
        chk(violation, 1'b0, "R11 code 0 not flagged");
        fire(C_SPARE, 2);
        chk(violation, 1'b0, "R11 code 7 not flagged");
        probe(C_ACT, 2, 1'b1, "R11 no-op leaves activate window untouched");
        probe(C_PRE, 2, 1'b1, "R11 no-op opened nothing");
    endtask

    task automatic t_rrd();
        do_reset();
        fire(C_ACT, 0);
        idle(E_RRD - 2);
        probe(C_ACT, 1, 1'b0, "R2 activate one cycle early");
        idle(1);
        probe(C_ACT, 1, 1'b1, "R2 activate at spacing");
    endtask

    task automatic t_faw();
        do_reset();
        for (int k = 0; k < 4; k++) begin
            probe(C_ACT, k, 1'b1, "R3 activate inside window");
            fire(C_ACT, k);
            if (k < 3) idle(E_RRD - 1);
        end
        idle(E_FAW - 3 * E_RRD - 2);
        probe(C_ACT, 4, 1'b0, "R3 fifth activate inside window");
        idle(1);
        probe(C_ACT, 4, 1'b1, "R3 fifth activate at window end");
    endtask

    task automatic t_rcd_ccd();
        do_reset();
        fire(C_ACT, 0);
        idle(E_RCD - 2);
        probe(C_RD, 0, 1'b0, "R4 read before activate delay");
        idle(1);
        probe(C_RD, 0, 1'b1, "R4 read at activate delay");
        probe(C_WR, 0, 1'b1, "R4 write at activate delay");
        fire(C_RD, 0);
        probe(C_WR, 0, 1'b0, "R5 column command too soon");
        idle(E_CCD - 1);
        probe(C_WR, 0, 1'b1, "R5 column command at spacing");
    endtask

    task automatic t_ras();
        do_reset();
        fire(C_ACT, 1);
        idle(E_RAS - 2);
        probe(C_PRE, 1, 1'b0, "R6 precharge before active time");
        probe(C_PREA, 0, 1'b0, "R6 precharge-all before active time");
        probe(C_PRE, 5, 1'b1, "R6 precharge of closed bank");
        idle(1);
        probe(C_PRE, 1, 1'b1, "R6 precharge at active time");
        probe(C_PREA, 0, 1'b1, "R6 precharge-all at active time");
    endtask

    task automatic t_rc();
        do_reset();
        fire(C_ACT, 2);
        idle(E_RAS - 1);
        fire(C_PRE, 2);
        idle(E_RC - E_RAS - 2);
        probe(C_ACT, 2, 1'b0, "R1 same-bank row cycle not met");
        idle(1);
        probe(C_ACT, 2, 1'b1, "R1 same-bank row cycle met");
    endtask

    task automatic t_rp(input bit all_banks);
        do_reset();
        fire(C_ACT, 3);
        idle(E_RC - 4);
        fire(all_banks ? C_PREA : C_PRE, 3);
        if (all_banks) begin
            idle(E_RPA - 2);
            probe(C_ACT, 3, 1'b0, "R7 reactivate before all-bank recovery");
        end else begin
            idle(E_RP - 2);
            probe(C_ACT, 3, 1'b0, "R7 reactivate before single-bank recovery");
        end
        idle(1);
        probe(C_ACT, 3, 1'b1, "R7 reactivate at recovery");
    endtask

    task automatic t_violation();
        do_reset();
        fire(C_RD, 0);
        chk(violation, 1'b1, "R8 flag after blocked read");
        idle(1);
        chk(violation, 1'b0, "R8 flag lasts one cycle");
        fire(C_ACT, 0);
        chk(violation, 1'b0, "R8 no flag for allowed activate");
        fire(C_ACT, 1);
        chk(violation, 1'b1, "R8 flag for activate inside spacing");
        probe(C_ACT, 1, 1'b0, "R8 blocked activate still opened bank");
        idle(E_RCD - 1);
        probe(C_RD, 1, 1'b1, "R8 blocked activate recorded for read timing");
    endtask

    task automatic t_overrun();
        do_reset();
        fire(C_ACT, 6);
        idle(E_RASMAX - 1);
        chk(ras_overrun, 1'b0, "R9 overrun at maximum active time");
        idle(1);
        chk(ras_overrun, 1'b1, "R9 overrun past maximum active time");
        fire(C_PRE, 6);
        chk(ras_overrun, 1'b0, "R9 overrun cleared by precharge");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_noop();
        t_rrd();
        t_faw();
        t_rcd_ccd();
        t_ras();
        t_rc();
        t_rp(1'b0);
        t_rp(1'b1);
        t_violation();
        t_overrun();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule